// File: doc/BRIEF.md
# Event Counter Bank with Threshold Interrupts

This block holds a bank of event counters. Each counter advances by one for each single-cycle pulse on its own event input. Software loads a start value into a counter and programs a limit for it. When an increment brings the count onto that limit, and the counter's interrupt enable is set, the counter latches an interrupt flag. One output line carries the OR of all latched flags.

Software reaches the bank through a simple auxiliary register port. The port has a write strobe, a 12-bit address, 32-bit write data and read data that is decoded combinationally. An index register selects which counter the per-counter registers address. A control register holds a global run bit and two action bits. One action clears every count; the other copies every live count into a shadow copy.

Reads of the count pair always return the shadow copy, so the low and high words of one reading belong to the same instant. A read-only build word describes the configuration to software.

Top module: `evc_bank`

## Requirements
- R1: After reset every count, shadow, limit, local enable, interrupt-enable bit and interrupt-active bit is zero, the index and run bit are zero, and `irq_o` is low.
- R2: A pulse on `ev_i[i]` adds one to counter i in the next cycle only while the run bit (control 0x255 bit 0) and the counter's local enable (0x254 bit 0, written for the indexed counter) are both 1. The count wraps modulo 2^W, where W = 32 + 16·SIZE_CODE.
- R3: When an increment makes counter i equal to its limit and enable bit i was 1 before that edge, active bit i is 1 after that edge. With enable bit i at 0, no flag is latched.
- R4: Register 0x25E holds one enable bit per counter, with bit i for counter i. It is written and read as a whole word.
- R5: Register 0x25F reads the active bits. Writing 1 to bit i clears both active bit i and enable bit i on the same edge. This clear wins over a limit match on counter i in that same cycle.
- R6: `irq_o` is 1 exactly while any active bit is 1. It stays high until the last pending flag has been cleared.
- R7: A control write with bit 16 set zeroes all counts. A control write with bit 17 set copies every count (its value before that edge) into that counter's shadow. The count pair (0x257 low, 0x258 high) reads the shadow of the indexed counter.
- R8: Writes to 0x257 and 0x258 replace bits 31:0 and bits W-1:32 of the indexed counter's live count. Such a write wins over an event in the same cycle.
- R9: The limit pair (0x25C low, 0x25D high) writes and reads back the indexed counter's limit, with bits 31:0 in the low word and bits W-1:32 in the high word.
- R10: The build word at 0x251 holds these fields: version in bits 7:0, SIZE_CODE in bits 9:8, interrupt support (1) in bit 10, zero in bits 15:11, the counter count in bits 23:16 and BUILD_M in bits 31:24. SIZE_CODE may be 0, 1 or 2.
- R11: When the index names no counter, writes to the per-counter registers (0x254, 0x257, 0x258, 0x25C, 0x25D) change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_wr | input | 1 | Register write strobe |
| aux_addr | input | 12 | Register address |
| aux_wdata | input | 32 | Register write data |
| aux_rdata | output | 32 | Read data for `aux_addr`, combinational |
| ev_i | input | N_CTR | One event pulse per counter |
| irq_o | output | 1 | OR of all interrupt-active bits |

## Verification
The assertions assume that at most one register write happens per cycle, and that the address is stable whenever the strobe is high. Under that assumption, an enable bit can rise only through a write to the enable register, and an active bit or the output line can fall only through an acknowledge write. The stimulus drives one register access or one idle cycle per clock, always on the falling edge. The random phase issues acknowledges, re-enables, clears and snapshots only as whole single-cycle writes between bursts of events.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_BUILD = 12'h251;
    localparam logic [AW-1:0] A_CFG   = 12'h254;
    localparam logic [AW-1:0] A_CTRL  = 12'h255;
    localparam logic [AW-1:0] A_IDX   = 12'h256;
    localparam logic [AW-1:0] A_CLO   = 12'h257;
    localparam logic [AW-1:0] A_CHI   = 12'h258;
    localparam logic [AW-1:0] A_LLO   = 12'h25C;
    localparam logic [AW-1:0] A_LHI   = 12'h25D;
    localparam logic [AW-1:0] A_IEN   = 12'h25E;
    localparam logic [AW-1:0] A_IACT  = 12'h25F;

    // software-visible layout of the build word, LSB last
    typedef struct packed {
        logic [7:0] m_field;
        logic [7:0] n_ctr;
        logic [4:0] rsvd;
        logic       irq_ok;
        logic [1:0] size;
        logic [7:0] version;
    } build_t;

    // one decoded write strobe per register
    typedef struct packed {
        logic cfg;
        logic ctrl;
        logic idx;
        logic cnt_lo;
        logic cnt_hi;
        logic lim_lo;
        logic lim_hi;
        logic ien;
        logic iact;
    } wstb_t;

endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
    parameter int W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_i,
    input  logic               run_i,
    input  logic               sel_i,
    input  evc_pkg::wstb_t     wstb_i,
    input  logic [31:0]        wdata_i,
    input  logic               clr_i,
    input  logic               snap_i,
    output logic               hit_o,
    output logic               en_o,
    output logic [W-1:0]       shadow_o,
    output logic [W-1:0]       limit_o
);

    typedef struct packed {
        logic         en;
        logic [W-1:0] cnt;
        logic [W-1:0] shd;
        logic [W-1:0] lim;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [W-1:0] put_lo(input logic [W-1:0] old, input logic [31:0] v);
        logic [63:0] t;
        t = 64'(old);
        t[31:0] = v;
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] put_hi(input logic [W-1:0] old, input logic [31:0] v);
        logic [63:0] t;
        t = 64'(old);
        t[63:32] = v;
        return t[W-1:0];
    endfunction

    logic         ld_lo, ld_hi, inc;
    logic [W-1:0] nxt;

    always_comb begin
        s_d   = s_q;
        ld_lo = sel_i && wstb_i.cnt_lo;
        ld_hi = sel_i && wstb_i.cnt_hi;
        nxt   = s_q.cnt + 1'b1;
        inc   = ev_i && run_i && s_q.en && !ld_lo && !ld_hi && !clr_i;
        hit_o = inc && (nxt == s_q.lim);

        if (inc)   s_d.cnt = nxt;
        if (ld_lo) s_d.cnt = put_lo(s_q.cnt, wdata_i);
        if (ld_hi) s_d.cnt = put_hi(s_q.cnt, wdata_i);
        if (clr_i) s_d.cnt = '0;

        if (snap_i) s_d.shd = s_q.cnt;

        if (sel_i && wstb_i.lim_lo) s_d.lim = put_lo(s_q.lim, wdata_i);
        if (sel_i && wstb_i.lim_hi) s_d.lim = put_hi(s_q.lim, wdata_i);
        if (sel_i && wstb_i.cfg)    s_d.en  = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o     = s_q.en;
    assign shadow_o = s_q.shd;
    assign limit_o  = s_q.lim;

endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    input  logic         wr_ien_i,
    input  logic         wr_iact_i,
    input  logic [N-1:0] wmask_i,
    output logic [N-1:0] ien_o,
    output logic [N-1:0] iact_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] ien;
        logic [N-1:0] iact;
    } st_t;

    st_t s_d, s_q;
    logic [N-1:0] ack;

    always_comb begin
        s_d    = s_q;
        ack    = wr_iact_i ? wmask_i : '0;
        if (wr_ien_i) s_d.ien = wmask_i;
        // an acknowledge drops the enable too and beats a same-cycle match
        s_d.ien  = s_d.ien & ~ack;
        s_d.iact = (s_q.iact | (hit_i & s_q.ien)) & ~ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ien_o  = s_q.ien;
    assign iact_o = s_q.iact;
    assign irq_o  = |s_q.iact;

endmodule

// File: rtl/evc_regif.sv
module evc_regif
    import evc_pkg::*;
#(
    parameter int         N         = 4,
    parameter int         SIZE_CODE = 1,
    parameter logic [7:0] VERSION   = 8'h03,
    parameter logic [7:0] BUILD_M   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [7:0]        wlow_i,
    input  logic              clr_bit_i,
    input  logic              snap_bit_i,
    input  logic              cfg_en_i,
    input  logic [63:0]       shd_i,
    input  logic [63:0]       lim_i,
    input  logic [N-1:0]      ien_i,
    input  logic [N-1:0]      iact_i,
    output wstb_t             wstb_o,
    output logic [7:0]        idx_o,
    output logic              run_o,
    output logic              clr_o,
    output logic              snap_o,
    output logic [DW-1:0]     rdata_o
);

    typedef struct packed {
        logic [7:0] idx;
        logic       run;
    } st_t;

    st_t    s_d, s_q;
    build_t bld;

    always_comb begin
        wstb_o        = '0;
        wstb_o.cfg    = wr_i && (addr_i == A_CFG);
        wstb_o.ctrl   = wr_i && (addr_i == A_CTRL);
        wstb_o.idx    = wr_i && (addr_i == A_IDX);
        wstb_o.cnt_lo = wr_i && (addr_i == A_CLO);
        wstb_o.cnt_hi = wr_i && (addr_i == A_CHI);
        wstb_o.lim_lo = wr_i && (addr_i == A_LLO);
        wstb_o.lim_hi = wr_i && (addr_i == A_LHI);
        wstb_o.ien    = wr_i && (addr_i == A_IEN);
        wstb_o.iact   = wr_i && (addr_i == A_IACT);

        s_d = s_q;
        if (wstb_o.ctrl) s_d.run = wlow_i[0];
        if (wstb_o.idx)  s_d.idx = wlow_i;

        clr_o  = wstb_o.ctrl && clr_bit_i;
        snap_o = wstb_o.ctrl && snap_bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bld         = '0;
        bld.version = VERSION;
        bld.size    = SIZE_CODE[1:0];
        bld.irq_ok  = 1'b1;
        bld.n_ctr   = 8'(N);
        bld.m_field = BUILD_M;

        unique case (addr_i)
            A_BUILD: rdata_o = bld;
            A_CFG:   rdata_o = {31'd0, cfg_en_i};
            A_CTRL:  rdata_o = {31'd0, s_q.run};
            A_IDX:   rdata_o = {24'd0, s_q.idx};
            A_CLO:   rdata_o = shd_i[31:0];
            A_CHI:   rdata_o = shd_i[63:32];
            A_LLO:   rdata_o = lim_i[31:0];
            A_LHI:   rdata_o = lim_i[63:32];
            A_IEN:   rdata_o = 32'(ien_i);
            A_IACT:  rdata_o = 32'(iact_i);
            default: rdata_o = '0;
        endcase
    end

    assign idx_o = s_q.idx;
    assign run_o = s_q.run;

endmodule

// File: rtl/evc_bank.sv
module evc_bank #(
    parameter int         N_CTR     = 4,
    parameter int         SIZE_CODE = 1,
    parameter logic [7:0] VERSION   = 8'h03,
    parameter logic [7:0] BUILD_M   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_wr,
    input  logic [11:0]       aux_addr,
    input  logic [31:0]       aux_wdata,
    output logic [31:0]       aux_rdata,
    input  logic [N_CTR-1:0]  ev_i,
    output logic              irq_o
);

    localparam int W = 32 + 16 * SIZE_CODE;

    evc_pkg::wstb_t wstb;
    logic [7:0]     idx_w;
    logic           run_w, clr_w, snap_w;
    logic [N_CTR-1:0] sel_w, hit_w, en_w, ien_w, iact_w;
    logic [W-1:0]   shd_a [N_CTR];
    logic [W-1:0]   lim_a [N_CTR];
    logic           sel_en;
    logic [63:0]    sel_shd, sel_lim;

    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
        assign sel_w[i] = (idx_w == 8'(i));

        evc_counter #(.W(W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev_i[i]),
            .run_i    (run_w),
            .sel_i    (sel_w[i]),
            .wstb_i   (wstb),
            .wdata_i  (aux_wdata),
            .clr_i    (clr_w),
            .snap_i   (snap_w),
            .hit_o    (hit_w[i]),
            .en_o     (en_w[i]),
            .shadow_o (shd_a[i]),
            .limit_o  (lim_a[i])
        );
    end

    always_comb begin
        sel_en  = 1'b0;
        sel_shd = '0;
        sel_lim = '0;
        for (int i = 0; i < N_CTR; i++) begin
            if (sel_w[i]) begin
                sel_en  = en_w[i];
                sel_shd = 64'(shd_a[i]);
                sel_lim = 64'(lim_a[i]);
            end
        end
    end

    evc_regif #(
        .N         (N_CTR),
        .SIZE_CODE (SIZE_CODE),
        .VERSION   (VERSION),
        .BUILD_M   (BUILD_M)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (aux_wr),
        .addr_i     (aux_addr),
        .wlow_i     (aux_wdata[7:0]),
        .clr_bit_i  (aux_wdata[16]),
        .snap_bit_i (aux_wdata[17]),
        .cfg_en_i   (sel_en),
        .shd_i      (sel_shd),
        .lim_i      (sel_lim),
        .ien_i      (ien_w),
        .iact_i     (iact_w),
        .wstb_o     (wstb),
        .idx_o      (idx_w),
        .run_o      (run_w),
        .clr_o      (clr_w),
        .snap_o     (snap_w),
        .rdata_o    (aux_rdata)
    );

    evc_irq #(.N(N_CTR)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit_w),
        .wr_ien_i  (wstb.ien),
        .wr_iact_i (wstb.iact),
        .wmask_i   (aux_wdata[N_CTR-1:0]),
        .ien_o     (ien_w),
        .iact_o    (iact_w),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         aux_wr,
    input logic [11:0]  aux_addr,
    input logic [N-1:0] wmask,
    input logic [N-1:0] ien,
    input logic [N-1:0] iact,
    input logic         irq_o
);
    import evc_pkg::*;

    AST_ACK_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr && aux_addr == A_IACT) |=> (((ien | iact) & $past(wmask)) == '0)); // R5

    AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((iact & ~$past(iact) & ~$past(ien)) == '0)); // R3

    AST_FLAG_FALLS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((~iact & $past(iact)) != '0) |-> $past(aux_wr && aux_addr == A_IACT)); // R5

    AST_IRQ_FALLS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(aux_wr && aux_addr == A_IACT)); // R6

    AST_ENABLE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ien & ~$past(ien)) != '0) |-> $past(aux_wr && aux_addr == A_IEN)); // R4

endmodule

bind evc_bank evc_bank_chk #(.N(N_CTR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .aux_wr   (aux_wr),
    .aux_addr (aux_addr),
    .wmask    (aux_wdata[N_CTR-1:0]),
    .ien      (ien_w),
    .iact     (iact_w),
    .irq_o    (irq_o)
);

// File: tb/tb_evc_bank.sv
module tb_evc_bank;
    import evc_pkg::*;

    localparam int NC = 4;
    localparam int SC = 1;
    localparam int WD = 32 + 16 * SC;
    localparam longint unsigned MASK = (64'd1 << WD) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aux_wr = 1'b0;
    logic [11:0] aux_addr = '0;
    logic [31:0] aux_wdata = '0;
    logic [31:0] aux_rdata;
    logic [NC-1:0] ev = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    evc_bank #(.N_CTR(NC), .SIZE_CODE(SC), .VERSION(8'h03), .BUILD_M(8'h00)) dut (
        .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .ev_i(ev), .irq_o(irq_o)
    );

    // reference state
    longint unsigned m_cnt [NC];
    longint unsigned m_shd [NC];
    longint unsigned m_lim [NC];
    bit              m_cen [NC];
    int              m_idx;
    bit              m_run;
    bit [NC-1:0]     m_ien, m_iact;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [11:0] a);
        bit ok;
        ok = (m_idx < NC);
        case (a)
            A_BUILD: return 32'h03 | (32'(SC) << 8) | (32'd1 << 10) | (32'(NC) << 16);
            A_CFG:   return ok ? {31'd0, m_cen[m_idx]} : 32'd0;
            A_CTRL:  return {31'd0, m_run};
            A_IDX:   return 32'(m_idx);
            A_CLO:   return ok ? m_shd[m_idx][31:0] : 32'd0;
            A_CHI:   return ok ? m_shd[m_idx][63:32] : 32'd0;
            A_LLO:   return ok ? m_lim[m_idx][31:0] : 32'd0;
            A_LHI:   return ok ? m_lim[m_idx][63:32] : 32'd0;
            A_IEN:   return 32'(m_ien);
            A_IACT:  return 32'(m_iact);
            default: return 32'd0;
        endcase
    endfunction

    task automatic mstep(input bit wr, input logic [11:0] a, input logic [31:0] d, input logic [NC-1:0] e);
        bit clr, snap, sel, ldc;
        bit [NC-1:0] hit, ackm;
        longint unsigned nc;
        clr  = wr && a == A_CTRL && d[16];
        snap = wr && a == A_CTRL && d[17];
        hit  = '0;
        for (int i = 0; i < NC; i++) begin
            sel = wr && (m_idx == i);
            ldc = sel && (a == A_CLO || a == A_CHI);
            nc  = m_cnt[i];
            if (e[i] && m_run && m_cen[i] && !ldc && !clr) begin
                nc = (m_cnt[i] + 1) & MASK;
                hit[i] = (nc == m_lim[i]);
            end
            if (sel && a == A_CLO) nc = (m_cnt[i] & ~64'hFFFF_FFFF) | 64'(d);
            if (sel && a == A_CHI) nc = ((64'(d) << 32) | (m_cnt[i] & 64'hFFFF_FFFF)) & MASK;
            if (clr) nc = 0;
            if (snap) m_shd[i] = m_cnt[i];
            m_cnt[i] = nc;
            if (sel && a == A_LLO) m_lim[i] = (m_lim[i] & ~64'hFFFF_FFFF) | 64'(d);
            if (sel && a == A_LHI) m_lim[i] = ((64'(d) << 32) | (m_lim[i] & 64'hFFFF_FFFF)) & MASK;
            if (sel && a == A_CFG) m_cen[i] = d[0];
        end
        ackm   = (wr && a == A_IACT) ? d[NC-1:0] : '0;
        m_iact = (m_iact | (hit & m_ien)) & ~ackm;
        if (wr && a == A_IEN) m_ien = d[NC-1:0];
        m_ien = m_ien & ~ackm;
        if (wr && a == A_CTRL) m_run = d[0];
        if (wr && a == A_IDX)  m_idx = int'(d[7:0]);
    endtask

    task automatic cyc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [NC-1:0] e, input bit chk, input string tag);
        @(negedge clk);
        check("R6 irq", {31'd0, irq_o}, {31'd0, (m_iact != 0)});
        aux_wr = wr; aux_addr = a; aux_wdata = d; ev = e;
        #1;
        if (chk) check(tag, aux_rdata, mread(a));
        @(posedge clk);
        mstep(wr, a, d, e);
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, '0, 1'b0, "");
    endtask

    task automatic rreg(input logic [11:0] a, input string tag);
        cyc(1'b0, a, 32'd0, '0, 1'b1, tag);
    endtask

    task automatic pulse(input logic [NC-1:0] e, input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 12'h000, 32'd0, e, 1'b0, "");
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NC; i++) begin
            m_cnt[i] = 0; m_shd[i] = 0; m_lim[i] = 0; m_cen[i] = 0;
        end
        m_idx = 0; m_run = 0; m_ien = '0; m_iact = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rreg(A_CTRL, "R1"); rreg(A_IDX, "R1"); rreg(A_IEN, "R1");
        rreg(A_IACT, "R1"); rreg(A_LLO, "R1"); rreg(A_CLO, "R1"); rreg(A_CFG, "R1");
        // R10 build word
        rreg(A_BUILD, "R10");

        // R2 R3 R4 R9: counter 0 to limit 5
        wreg(A_CTRL, 32'd1); wreg(A_IDX, 32'd0); wreg(A_CFG, 32'd1);
        wreg(A_LLO, 32'd5); wreg(A_LHI, 32'h1234);
        rreg(A_LLO, "R9"); rreg(A_LHI, "R9"); rreg(A_CFG, "R2");
        wreg(A_LHI, 32'd0);
        wreg(A_IEN, 32'd1); rreg(A_IEN, "R4");
        pulse(4'b0001, 4);
        rreg(A_IACT, "R3");
        pulse(4'b0001, 1);
        rreg(A_IACT, "R3"); rreg(A_IEN, "R4");

        // R5 acknowledge clears active and enable
        wreg(A_IACT, 32'd1);
        rreg(A_IACT, "R5"); rreg(A_IEN, "R5");

        // R3 no latch with enable clear
        wreg(A_IDX, 32'd1); wreg(A_CFG, 32'd1); wreg(A_LLO, 32'd2);
        pulse(4'b0010, 2);
        rreg(A_IACT, "R3");

        // R6 two flags, ack one at a time
        wreg(A_CLO, 32'd0);
        wreg(A_IDX, 32'd0); wreg(A_CLO, 32'd3);
        wreg(A_IEN, 32'd3);
        pulse(4'b0011, 2);
        rreg(A_IACT, "R6");
        wreg(A_IACT, 32'd1);
        rreg(A_IACT, "R6");
        wreg(A_IACT, 32'd2);
        rreg(A_IACT, "R6");

        // R5 acknowledge meets match in the same cycle
        wreg(A_IDX, 32'd2); wreg(A_CFG, 32'd1); wreg(A_LLO, 32'd20);
        wreg(A_CLO, 32'd19); wreg(A_IEN, 32'd4);
        cyc(1'b1, A_IACT, 32'd4, 4'b0100, 1'b0, "");
        rreg(A_IACT, "R5"); rreg(A_IEN, "R5");
        pulse(4'b0100, 1);
        rreg(A_IACT, "R5");

        // R7 snapshot then clear
        wreg(A_CTRL, 32'h0002_0001);
        rreg(A_CLO, "R7"); rreg(A_CHI, "R7");
        wreg(A_CTRL, 32'h0001_0001);
        rreg(A_CLO, "R7");
        wreg(A_CTRL, 32'h0002_0001);
        rreg(A_CLO, "R7");

        // R2 wrap and full-scale limit, R8 load beats event
        wreg(A_IDX, 32'd3); wreg(A_CFG, 32'd1);
        wreg(A_CLO, 32'hFFFF_FFFE); wreg(A_CHI, 32'hFFFF_FFFF);
        wreg(A_LLO, 32'hFFFF_FFFF); wreg(A_LHI, 32'h0000_FFFF);
        rreg(A_LHI, "R9");
        wreg(A_IEN, 32'd8);
        pulse(4'b1000, 1);
        rreg(A_IACT, "R3");
        wreg(A_CTRL, 32'h0002_0001);
        rreg(A_CLO, "R2"); rreg(A_CHI, "R2");
        pulse(4'b1000, 1);
        wreg(A_CTRL, 32'h0002_0001);
        rreg(A_CLO, "R2"); rreg(A_CHI, "R2");
        cyc(1'b1, A_CLO, 32'd10, 4'b1000, 1'b0, "");
        wreg(A_CTRL, 32'h0002_0001);
        rreg(A_CLO, "R8");
        wreg(A_IACT, 32'hFFFF_FFFF);

        // R11 index out of range
        wreg(A_IDX, 32'd7);
        wreg(A_LLO, 32'd9); wreg(A_CFG, 32'd1); wreg(A_CLO, 32'd77);
        rreg(A_LLO, "R11"); rreg(A_CFG, "R11"); rreg(A_CLO, "R11");
        wreg(A_IDX, 32'd0);
        rreg(A_LLO, "R11");
        wreg(A_CTRL, 32'h0002_0001);
        rreg(A_CLO, "R11");

        // R2 run bit off blocks counting
        wreg(A_CTRL, 32'd0);
        pulse(4'b1111, 3);
        wreg(A_CTRL, 32'h0002_0000);
        rreg(A_CLO, "R2");

        // mixed traffic
        for (int i = 0; i < NC; i++) begin
            wreg(A_IDX, 32'(i)); wreg(A_CFG, 32'd1);
            wreg(A_LLO, 32'(6 + 2 * i)); wreg(A_LHI, 32'd0);
            wreg(A_CLO, 32'd0); wreg(A_CHI, 32'd0);
        end
        wreg(A_CTRL, 32'd1); wreg(A_IEN, 32'hF);
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[7:4])
                4'd0: wreg(A_IACT, {28'd0, lfsr[11:8]});
                4'd1: wreg(A_IEN, {28'd0, lfsr[11:8]});
                4'd2: wreg(A_CTRL, 32'h0002_0001);
                4'd3: rreg(A_CLO, "R7");
                4'd4: wreg(A_CTRL, 32'h0001_0001);
                4'd5: rreg(A_IACT, "R3");
                4'd6: wreg(A_IDX, {30'd0, lfsr[9:8]});
                default: pulse(lfsr[3:0], 1);
            endcase
        end
        rreg(A_IEN, "R4");
        wreg(A_IACT, 32'hFFFF_FFFF);
        rreg(A_IACT, "R5");
        finish_run();
    end

endmodule